// File: doc/BRIEF.md
# Network Controller Interrupt Status and Acknowledge Unit

This unit collects event pulses from the rest of a network controller and holds them as sticky status bits. The sources are command completion, frame reception, the command engine going inactive, the receive engine running out of buffers, a finished management-bus cycle, a software event and a flow-control pause. A host reads the status byte through a small register port and acknowledges events by writing ones to the bits it has handled. It also programs a control byte that holds a global interrupt mask, a software interrupt request and four per-source masks.

A single level-sensitive interrupt line is computed from the state that the next clock edge will hold, and then registered. The line therefore changes on the same edge as the status or control byte that caused the change. The decision has a fixed priority. The global mask wins over everything. After it comes the software request. Last is the OR of the four upper status bits, each gated by its own mask bit.

Top module: `nic_irq_status`

## Requirements
- R1: A synchronous reset clears the status byte and the control byte, drives `irq_o` low and clears `rdata_o`.
- R2: An `evt_i` bit that is high in a cycle sets the status bit at the same position on that clock edge. Implemented positions are 7, 6, 5, 4, 3, 2 and 0. Position 1 is never set and always reads 0.
- R3: `rdata_o` is registered from `addr_i` in the previous cycle. Offset 2 returns `{status, 8'h00}`, offset 3 returns `{8'h00, status}` and offset 0 returns `{8'h00, control}`. Offset 1 returns 0. Reading has no side effect.
- R4: A write to offset 2 clears every status bit whose position in `wdata_i[15:8]` is 1. A write to offset 3 clears using `wdata_i[7:0]`. Status bits written with 0 keep their value.
- R5: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R6: A write to offset 0 loads the control byte from `wdata_i[7:0]`. A write to offset 1 changes neither the control byte nor the status byte.
- R7: While control bit 0 (global mask) is 1, `irq_o` is low.
- R8: While control bit 0 is 0 and control bit 1 (software request) is 1, `irq_o` is high.
- R9: While control bits 1:0 are both 0, `irq_o` is high exactly when a status bit in 7:4 is 1 and the control bit at the same position is 0. Status bits 3, 2 and 0 never raise `irq_o`.
- R10: `irq_o` reflects a status change or control change on the same clock edge that makes that change. There is no extra cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Event pulses, one per status bit position |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register byte offset |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Registered read data for the offset of the previous cycle |
| irq_o | output | 1 | Registered level interrupt output |

## Verification
The assertions assume that `evt_i` and the write port are only meaningful outside reset. They also assume that a write carries its clear mask in the byte lane that matches its offset. The bench releases reset before it drives any event or write, and it uses those lanes. The properties that check the interrupt read the registered control and status byte. They hold because those registers and `irq_o` are all loaded on the same edge. The stimulus changes inputs only between edges and holds each event for exactly one cycle.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  // byte offsets seen by the host
  localparam logic [1:0] OFS_CTRL      = 2'd0;
  localparam logic [1:0] OFS_SPARE     = 2'd1;
  localparam logic [1:0] OFS_STAT_WORD = 2'd2;
  localparam logic [1:0] OFS_STAT_BYTE = 2'd3;
  // control byte bit positions
  localparam int CTRL_GMASK = 0;
  localparam int CTRL_SWREQ = 1;
endpackage

// File: rtl/nic_irq_stat_bits.sv
module nic_irq_stat_bits #(
  parameter int               STAT_W    = 8,
  parameter logic [STAT_W-1:0] IMPL_BITS = 8'hFD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] stat_d_o,
  output logic [STAT_W-1:0] stat_q_o
);
  logic [STAT_W-1:0] nxt;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (IMPL_BITS[i]) begin : g_impl
      // a set in the same cycle overrides the acknowledge
      assign nxt[i] = (stat_q_o[i] & ~clr_i[i]) | set_i[i];
    end else begin : g_rsvd
      assign nxt[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q_o <= '0;
    else     stat_q_o <= nxt;
  end

  assign stat_d_o = rst ? '0 : nxt;
endmodule

// File: rtl/nic_irq_ctrl_reg.sv
module nic_irq_ctrl_reg #(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [CTRL_W-1:0] val_i,
  output logic [CTRL_W-1:0] ctrl_d_o,
  output logic [CTRL_W-1:0] ctrl_q_o
);
  always_comb begin
    if (rst)         ctrl_d_o = '0;
    else if (load_i) ctrl_d_o = val_i;
    else             ctrl_d_o = ctrl_q_o;
  end

  always_ff @(posedge clk) ctrl_q_o <= ctrl_d_o;
endmodule

// File: rtl/nic_irq_decide.sv
module nic_irq_decide
  import nic_irq_pkg::*;
#(
  parameter int               STAT_W   = 8,
  parameter logic [STAT_W-1:0] SRC_BITS = 8'hF0
) (
  input  logic [STAT_W-1:0] ctrl_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              irq_o
);
  logic hw_pend;
  assign hw_pend = |(stat_i & SRC_BITS & ~ctrl_i);

  always_comb begin
    if (ctrl_i[CTRL_GMASK])      irq_o = 1'b0;
    else if (ctrl_i[CTRL_SWREQ]) irq_o = 1'b1;
    else                         irq_o = hw_pend;
  end
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
  import nic_irq_pkg::*;
#(
  parameter int                    DATA_W    = 16,
  parameter int                    ADDR_W    = 2,
  parameter logic [DATA_W/2-1:0]   IMPL_BITS = 8'hFD,
  parameter logic [DATA_W/2-1:0]   SRC_BITS  = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W/2-1:0] evt_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int BYTE_W = DATA_W / 2;

  logic [BYTE_W-1:0] stat_d, stat_q, ctrl_d, ctrl_q, clr_mask;
  logic              ctrl_load, irq_d;

  assign ctrl_load = we_i && (addr_i == ADDR_W'(OFS_CTRL));

  always_comb begin
    clr_mask = '0;
    if (we_i && addr_i == ADDR_W'(OFS_STAT_WORD)) clr_mask = wdata_i[DATA_W-1:BYTE_W];
    else if (we_i && addr_i == ADDR_W'(OFS_STAT_BYTE)) clr_mask = wdata_i[BYTE_W-1:0];
  end

  nic_irq_stat_bits #(.STAT_W(BYTE_W), .IMPL_BITS(IMPL_BITS)) u_stat (
    .clk(clk), .rst(rst), .set_i(evt_i), .clr_i(clr_mask),
    .stat_d_o(stat_d), .stat_q_o(stat_q));

  nic_irq_ctrl_reg #(.CTRL_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst(rst), .load_i(ctrl_load), .val_i(wdata_i[BYTE_W-1:0]),
    .ctrl_d_o(ctrl_d), .ctrl_q_o(ctrl_q));

  // decision on next-state values so the line moves with the registers
  nic_irq_decide #(.STAT_W(BYTE_W), .SRC_BITS(SRC_BITS)) u_dec (
    .ctrl_i(ctrl_d), .stat_i(stat_d), .irq_o(irq_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      irq_o <= irq_d;
      case (addr_i)
        ADDR_W'(OFS_CTRL):      rdata_o <= {{BYTE_W{1'b0}}, ctrl_q};
        ADDR_W'(OFS_STAT_WORD): rdata_o <= {stat_q, {BYTE_W{1'b0}}};
        ADDR_W'(OFS_STAT_BYTE): rdata_o <= {{BYTE_W{1'b0}}, stat_q};
        default:                rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/nic_irq_status_chk.sv
module nic_irq_status_chk #(
  parameter int               BYTE_W    = 8,
  parameter int               ADDR_W    = 2,
  parameter logic [BYTE_W-1:0] IMPL_BITS = 8'hFD,
  parameter logic [BYTE_W-1:0] SRC_BITS  = 8'hF0
) (
  input logic                clk,
  input logic                rst,
  input logic [BYTE_W-1:0]   evt_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [2*BYTE_W-1:0] wdata_i,
  input logic [BYTE_W-1:0]   stat_q,
  input logic [BYTE_W-1:0]   ctrl_q,
  input logic                irq_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (stat_q == '0 && ctrl_q == '0 && !irq_o));
  // R2
  event_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((stat_q & $past(evt_i & IMPL_BITS)) == $past(evt_i & IMPL_BITS)));
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q & ~IMPL_BITS) == '0);
  // R4
  word_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i == ADDR_W'(2)) |=>
      ((stat_q & $past(wdata_i[2*BYTE_W-1:BYTE_W] & ~evt_i)) == '0));
  // R6
  spare_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i == ADDR_W'(1) && evt_i == '0) |=> ($stable(ctrl_q) && $stable(stat_q)));
  // R7
  global_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[0] |-> !irq_o);
  // R8
  sw_request_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[1] && !ctrl_q[0]) |-> irq_o);
  // R9
  hw_source_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[1:0] == 2'b00) |-> (irq_o == |(stat_q & SRC_BITS & ~ctrl_q)));
endmodule

bind nic_irq_status nic_irq_status_chk #(
  .BYTE_W(DATA_W/2), .ADDR_W(ADDR_W), .IMPL_BITS(IMPL_BITS), .SRC_BITS(SRC_BITS)
) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .stat_q(stat_q), .ctrl_q(ctrl_q), .irq_o(irq_o));

// File: tb/test_nic_irq_status.sv
module test_nic_irq_status;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  evt;
  logic        we;
  logic [1:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nic_irq_status i_nic_irq_status (
    .clk(clk), .rst(rst), .evt_i(evt), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a);
    addr = a;
    step();
  endtask

  function automatic logic exp_irq(input logic [7:0] c, input logic [7:0] s);
    if (c[0])      return 1'b0;
    else if (c[1]) return 1'b1;
    else           return |(s & 8'hF0 & ~c);
  endfunction

  initial begin
    rst = 1'b1; evt = '0; we = 1'b0; addr = 2'd2; wdata = '0;
    repeat (3) step();
    rst = 1'b0;
    step();
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 status read", rdata, 16'h0000);
    rd(2'd0);
    check("R1 control read", rdata, 16'h0000);

    // all events at once, reserved bit stays clear
    addr = 2'd2;
    evt = 8'hFF;
    step();
    evt = '0;
    check("R10 irq same edge", {15'd0, irq}, 16'd1);
    step();
    check("R2 status word", rdata, 16'hFD00);
    rd(2'd3);
    check("R3 status byte", rdata, 16'h00FD);
    rd(2'd1);
    check("R3 spare offset", rdata, 16'h0000);

    // acknowledge through both offsets
    wr(2'd2, 16'hA0FF);
    rd(2'd2);
    check("R4 word clear", rdata, 16'h5D00);
    wr(2'd3, 16'hFF15);
    rd(2'd2);
    check("R4 byte clear", rdata, 16'h4800);

    // spare offset writes do nothing
    wr(2'd1, 16'hFFFF);
    rd(2'd0);
    check("R6 control untouched", rdata, 16'h0000);
    rd(2'd2);
    check("R6 status untouched", rdata, 16'h4800);
    check("R9 bit6 unmasked", {15'd0, irq}, 16'd1);
    wr(2'd0, 16'h0040);
    check("R9 bit6 masked", {15'd0, irq}, 16'd0);
    rd(2'd0);
    check("R6 control load", rdata, 16'h0040);

    // event and clear collide
    wr(2'd0, 16'h0000);
    evt = 8'h80; we = 1'b1; addr = 2'd2; wdata = 16'hFF00;
    step();
    evt = '0; we = 1'b0; wdata = '0;
    check("R5 irq kept", {15'd0, irq}, 16'd1);
    step();
    check("R5 status kept", rdata, 16'h8000);

    // low status bits never interrupt
    wr(2'd2, 16'hFF00);
    evt = 8'h0D;
    step();
    evt = '0;
    check("R9 low bits silent", {15'd0, irq}, 16'd0);

    // sweep every control value against status patterns
    for (int c = 0; c < 256; c++) begin
      for (int k = 0; k < 16; k++) begin
        logic [7:0] s;
        string tag;
        s = 8'(k * 17);
        wr(2'd2, 16'hFF00);
        wr(2'd0, {8'h00, 8'(c)});
        evt = s;
        addr = 2'd2;
        step();
        evt = '0;
        tag = (c & 1) ? "R7 sweep" : ((c & 2) ? "R8 sweep" : "R9 sweep");
        check(tag, {15'd0, irq}, {15'd0, exp_irq(8'(c), s & 8'hFD)});
        if (c == 0 || c == 255) begin
          step();
          check("R2 sweep status", rdata, {s & 8'hFD, 8'h00});
        end
      end
    end

    wr(2'd2, 16'hFF00);
    rst = 1'b1;
    wr(2'd0, 16'h00F2);
    rst = 1'b0;
    rd(2'd0);
    check("R1 reset clears control", rdata, 16'h0000);
    check("R1 reset clears irq", {15'd0, irq}, 16'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule